// File: doc/BRIEF.md
# Edge-Triggered Interval Timer

This block is a 16-bit up-counter whose clock is a divided copy of the system clock and whose start and stop are controlled by edges on an external trigger pin. Software loads a starting value through four nibble-wide load registers. It then picks a divide ratio and the active edge polarity, and arms the timer with a GO bit. The first valid edge on the pin starts counting. When the count wraps from all ones to zero, the counter halts and, if enabled, raises a sticky interrupt request. The next valid edge starts it again.

An optional reverse-edge rule makes the opposite edge stop the counter and reload it from the load registers. Only trigger pulses wide enough to let the count reach its wrap point then produce an interrupt. This makes the block a pulse-width-qualified event detector as well as a one-shot interval timer.

The trigger pin passes through a two-flop synchroniser before edge detection. Reading a load nibble while the counter runs returns the live count instead of the stored value.

Top module: `trig_interval_timer`

## Requirements
- R1: Addresses 0..3 hold the load value, least significant nibble at address 0. A write to address 3 while GO is 0 copies the full 16-bit value, with address 3's new data as the top nibble, into the counter.
- R2: Register layout and readback:
  - address 4 holds GO (bit 3), reverse-edge enable (bit 2) and two mode bits (bits 1:0);
  - address 5 holds the polarity bit (bit 3) and the divide select (bits 2:0);
  - address 6 reads interrupt enable in bit 0 (writable) and the interrupt request in bit 1.
  - Reading address 0..3 returns the live counter nibble while counting, and the stored load nibble otherwise.
- R3: While GO is 1, writes to any load address leave the counter unchanged.
- R4: Counting starts only when GO is 1 and a valid trigger edge arrives. Polarity 0 selects falling edges and 1 selects rising edges. The counter is running from the third clock edge after the pin changes.
- R5: Divide select 0..7 gives divisors 4096, 1024, 256, 64, 16, 8, 4, 2. The divider restarts when counting starts, so the first increment lands one full divided period after the start.
- R6: On the wrap from 0xFFFF to 0x0000 the counter halts at zero. The interrupt request is set only if interrupt enable is 1.
- R7: After a halt on wrap, the next valid edge restarts counting from zero.
- R8: A valid edge arriving while the counter runs is ignored. With reverse-edge enable at 0, opposite edges are ignored.
- R9: With reverse-edge enable at 1, an opposite edge during counting stops the counter and reloads it from the load registers.
- R10: The interrupt request stays set until a write to address 7 with bit 0 set. Writing 0 there has no effect.
- R11: Clearing GO stops the counter and raises no interrupt.
- R12: After reset all registers read 0 and the interrupt request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Read data nibble, combinational on addr_i |
| trig_i | input | 1 | External trigger pin, asynchronous |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
A vector table sweeps the divide selects with both polarities. Each entry reads the live count a fixed number of cycles after the start edge, which separates the divisors and exposes an off-by-one in synchroniser latency or divider restart. Directed sequences place a wrong-polarity edge before a start, and extra start or opposite edges mid-count. These tell an ignored edge apart from a restart. Pairing the reverse-edge stop with a later restart shows whether the reload happened. Wrap tests sample the interrupt one cycle before and at the wrap edge, with enable on and off, and with GO dropped mid-count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] ADDR_CTRL    = 3'd4;
  localparam logic [2:0] ADDR_PRESC   = 3'd5;
  localparam logic [2:0] ADDR_IRQ_EN  = 3'd6;
  localparam logic [2:0] ADDR_IRQ_CLR = 3'd7;

  // log2 of the prescale divisor for each select code
  function automatic int unsigned div_log2(input logic [2:0] sel);
    case (sel)
      3'd0:    return 12;
      3'd1:    return 10;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 4;
      3'd5:    return 3;
      3'd6:    return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] chain_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  logic rise, fall;
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

  assign start_o = pol_i ? rise : fall;
  assign stop_o  = pol_i ? fall : rise;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= div_q + 1'b1;
  end

  assign mask   = {PRE_W{1'b1}} >> (PRE_W - div_log2(sel_i));
  assign tick_o = run_i && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             rev_i,
  input  logic             ie_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             start_ack_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, irq_q;
  logic             rev_stop, wrap;

  assign rev_stop    = run_q && rev_i && stop_i;
  assign wrap        = go_i && run_q && !rev_stop && tick_i && (cnt_q == CNT_MAX);
  assign start_ack_o = go_i && !run_q && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!go_i) begin
      run_q <= 1'b0;
      if (load_i) cnt_q <= load_val_i;
    end else if (run_q) begin
      if (rev_stop) begin
        run_q <= 1'b0;
        cnt_q <= reload_val_i;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_MAX) run_q <= 1'b0;
      end
    end else if (start_i) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (wrap && ie_i)      irq_q <= 1'b1;
    else if (irq_clr_i)         irq_q <= 1'b0;
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/trig_interval_timer.sv
module trig_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned PRE_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  output logic [NIB_W-1:0] rdata_o,
  input  logic             trig_i,
  output logic             irq_o
);
  localparam int unsigned N_NIB = CNT_W / NIB_W;

  logic [NIB_W-1:0] ld_nib [N_NIB];
  logic [CNT_W-1:0] ld_q;
  logic             go_q, rev_q, pol_q, ie_q;
  logic [1:0]       mode_q;
  logic [2:0]       sel_q;

  for (genvar g = 0; g < N_NIB; g++) begin : g_ld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ld_nib[g] <= '0;
      else if (wr_en_i && addr_i == 3'(g))      ld_nib[g] <= wdata_i;
    end
    assign ld_q[g*NIB_W +: NIB_W] = ld_nib[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      rev_q  <= 1'b0;
      mode_q <= '0;
      pol_q  <= 1'b0;
      sel_q  <= '0;
      ie_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          go_q   <= wdata_i[3];
          rev_q  <= wdata_i[2];
          mode_q <= wdata_i[1:0];
        end
        ADDR_PRESC: begin
          pol_q <= wdata_i[3];
          sel_q <= wdata_i[2:0];
        end
        ADDR_IRQ_EN: ie_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  logic             load_wr, irq_clr;
  logic [CNT_W-1:0] load_val;
  assign load_wr  = wr_en_i && (addr_i == 3'(N_NIB-1));
  assign load_val = {wdata_i, ld_q[CNT_W-NIB_W-1:0]};
  assign irq_clr  = wr_en_i && (addr_i == ADDR_IRQ_CLR) && wdata_i[0];

  logic start_pulse, stop_pulse, tick, running, start_ack;
  logic [CNT_W-1:0] cnt;

  tmr_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (trig_i),
    .pol_i   (pol_q),
    .start_o (start_pulse),
    .stop_o  (stop_pulse)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running),
    .clr_i  (start_ack),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go_q),
    .rev_i        (rev_q),
    .ie_i         (ie_q),
    .start_i      (start_pulse),
    .stop_i       (stop_pulse),
    .tick_i       (tick),
    .load_i       (load_wr),
    .load_val_i   (load_val),
    .reload_val_i (ld_q),
    .irq_clr_i    (irq_clr),
    .cnt_o        (cnt),
    .running_o    (running),
    .start_ack_o  (start_ack),
    .irq_o        (irq_o)
  );

  logic [CNT_W-1:0] rd_src;
  assign rd_src = running ? cnt : ld_q;

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < N_NIB) begin
      rdata_o = rd_src[int'(addr_i)*NIB_W +: NIB_W];
    end else begin
      case (addr_i)
        ADDR_CTRL:   rdata_o = {go_q, rev_q, mode_q};
        ADDR_PRESC:  rdata_o = {pol_q, sel_q};
        ADDR_IRQ_EN: rdata_o = {2'b00, irq_o, ie_q};
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_interval_checker.sv
module tmr_interval_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             go_i,
  input logic             rev_i,
  input logic             ie_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic             stop_i,
  input logic             irq_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_go_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_i |=> !run_i);

  assert_start_needs_go_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> $past(go_i));

  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && go_i && !tick_i && !(rev_i && stop_i)) |=> $stable(cnt_i));

  assert_step_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && go_i && tick_i && !(rev_i && stop_i) && cnt_i != CNT_MAX)
      |=> (cnt_i == $past(cnt_i) + 1'b1) && run_i);

  assert_wrap_halt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && go_i && tick_i && !(rev_i && stop_i) && cnt_i == CNT_MAX)
      |=> !run_i && cnt_i == '0);

  assert_irq_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(ie_i));

  assert_rev_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && go_i && rev_i && stop_i) |=> !run_i);
endmodule

bind trig_interval_timer tmr_interval_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .go_i   (go_q),
  .rev_i  (rev_q),
  .ie_i   (ie_q),
  .run_i  (running),
  .cnt_i  (cnt),
  .tick_i (tick),
  .stop_i (stop_pulse),
  .irq_i  (irq_o)
);

// File: tb/trig_interval_timer_bench.sv
module trig_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rdata_o;
  logic       trig_i = 1'b1;
  logic       irq_o;

  trig_interval_timer u_trig_interval_timer (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .trig_i  (trig_i),
    .irq_o   (irq_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // {sel[2:0], pol, wait[15:0]}
  localparam int NVEC = 7;
  localparam logic [19:0] VEC [NVEC] = '{
    {3'd7, 1'b0, 16'd13},
    {3'd6, 1'b1, 16'd23},
    {3'd5, 1'b0, 16'd43},
    {3'd4, 1'b1, 16'd35},
    {3'd3, 1'b0, 16'd200},
    {3'd2, 1'b1, 16'd600},
    {3'd0, 1'b0, 16'd4100}
  };

  function automatic int unsigned lg(input logic [2:0] s);
    case (s)
      3'd0: return 12; 3'd1: return 10; 3'd2: return 8; 3'd3: return 6;
      3'd4: return 4;  3'd5: return 3;  3'd6: return 2; default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rd16(output logic [15:0] v);
    for (int i = 0; i < 4; i++) begin
      logic [3:0] n;
      rd(3'(i), n);
      v[i*4 +: 4] = n;
    end
  endtask

  task automatic load16(input logic [15:0] v);
    for (int i = 0; i < 4; i++) wr(3'(i), v[i*4 +: 4]);
  endtask

  task automatic pin(input logic lvl, output int unsigned c0);
    @(negedge clk);
    trig_i = lvl;
    c0 = cyc;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  // disarm, set idle level, program, arm
  task automatic arm(input logic [15:0] ld, input logic [2:0] sel, input logic pol,
                     input logic rev, input logic ie);
    int unsigned c;
    wr(3'd4, {1'b0, rev, 2'b10});
    pin(~pol, c);
    settle(4);
    wr(3'd5, {pol, sel});
    wr(3'd6, {3'b0, ie});
    load16(ld);
    wr(3'd4, {1'b1, rev, 2'b10});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [3:0]  n;
    int unsigned c0, c1;

    repeat (3) @(posedge clk);
    #3;
    rst_ni = 1'b1;
    settle(2);

    // R12 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), n);
      chk("R12 reset readback", {28'd0, n}, 32'd0);
    end
    chk("R12 irq after reset", {31'd0, irq_o}, 32'd0);

    // R2 register readback
    wr(3'd4, 4'b0110);
    wr(3'd5, 4'b1011);
    wr(3'd6, 4'b0001);
    rd(3'd4, n); chk("R2 ctrl readback", {28'd0, n}, 32'h6);
    rd(3'd5, n); chk("R2 prescale readback", {28'd0, n}, 32'hB);
    rd(3'd6, n); chk("R2 irq enable readback", {28'd0, n}, 32'h1);
    load16(16'hA5C3);
    rd16(v); chk("R1 R2 idle load readback", {16'd0, v}, 32'hA5C3);

    // R5 vector walk over divide selects and polarities
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  s;
      logic        p;
      int unsigned w;
      s = VEC[i][19:17];
      p = VEC[i][16];
      w = int'(VEC[i][15:0]);
      arm(16'h1230, s, p, 1'b0, 1'b0);
      pin(p, c0);
      settle(w);
      rd16(v);
      chk("R5 R4 count per divisor", {16'd0, v}, 32'h1230 + ((cyc - c0 - 3) >> lg(s)));
    end

    // R4 wrong-polarity edge does not start
    arm(16'h4000, 3'd7, 1'b0, 1'b0, 1'b0);
    wr(3'd4, 4'b0010);
    pin(1'b0, c0);
    settle(4);
    wr(3'd4, 4'b1010);
    pin(1'b1, c0);
    settle(20);
    rd16(v);
    chk("R4 rising edge ignored with polarity 0", {16'd0, v}, 32'h4000);
    pin(1'b0, c0);
    settle(13);
    rd16(v);
    chk("R4 falling edge starts", {16'd0, v}, 32'h4000 + ((cyc - c0 - 3) >> 1));

    // R6 wrap with interrupt enabled, exact edge
    arm(16'hFFF0, 3'd7, 1'b0, 1'b0, 1'b1);
    pin(1'b0, c0);
    settle(34);
    chk("R6 no irq before wrap", {31'd0, irq_o}, 32'd0);
    settle(1);
    chk("R6 irq at wrap", {31'd0, irq_o}, 32'd1);
    rd16(v);
    chk("R6 halted, idle readback shows load", {16'd0, v}, 32'hFFF0);

    // R10 sticky irq
    wr(3'd7, 4'h0);
    settle(1);
    chk("R10 write 0 keeps irq", {31'd0, irq_o}, 32'd1);
    wr(3'd7, 4'h1);
    settle(1);
    chk("R10 write 1 clears irq", {31'd0, irq_o}, 32'd0);

    // R7 restart from zero, opposite edge ignored (R8)
    pin(1'b1, c0);
    settle(4);
    pin(1'b0, c0);
    settle(13);
    rd16(v);
    chk("R7 restart counts from zero", {16'd0, v}, (cyc - c0 - 3) >> 1);

    // R6 wrap with interrupt disabled
    arm(16'hFFF0, 3'd7, 1'b0, 1'b0, 1'b0);
    pin(1'b0, c0);
    settle(40);
    chk("R6 no irq when disabled", {31'd0, irq_o}, 32'd0);

    // R8 extra edges while running are ignored
    arm(16'h2000, 3'd7, 1'b0, 1'b0, 1'b0);
    pin(1'b0, c0);
    settle(10);
    pin(1'b1, c1);
    settle(4);
    pin(1'b0, c1);
    settle(8);
    rd16(v);
    chk("R8 mid-run edges ignored", {16'd0, v}, 32'h2000 + ((cyc - c0 - 3) >> 1));

    // R3 load writes while GO=1 leave the counter alone
    arm(16'h3000, 3'd7, 1'b1, 1'b0, 1'b0);
    pin(1'b1, c0);
    settle(6);
    load16(16'hFFFF);
    settle(1);
    rd16(v);
    chk("R3 writes under GO ignored", {16'd0, v}, 32'h3000 + ((cyc - c0 - 3) >> 1));

    // R9 opposite edge stops and reloads
    arm(16'h5000, 3'd7, 1'b1, 1'b1, 1'b0);
    pin(1'b1, c0);
    settle(30);
    pin(1'b0, c1);
    settle(6);
    pin(1'b1, c0);
    settle(13);
    rd16(v);
    chk("R9 reload on opposite edge", {16'd0, v}, 32'h5000 + ((cyc - c0 - 3) >> 1));

    // R11 clearing GO stops without irq
    arm(16'hFFF0, 3'd7, 1'b0, 1'b0, 1'b1);
    pin(1'b0, c0);
    settle(10);
    wr(3'd4, 4'b0010);
    settle(40);
    chk("R11 no irq after GO cleared", {31'd0, irq_o}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule